// File: doc/BRIEF.md
# Four-Port Shared-Media Repeater Core Controller

This block is the control core of a four-port 100 Mb/s shared-media repeater with one expansion port toward other repeaters. It runs on the 25 MHz symbol clock and takes one 5-bit symbol per cycle. Each twisted-pair port and the expansion port supply an activity flag and a symbol. Each cycle the core decides whether traffic is forwarded from one local port, forwarded from the expansion port, jammed because of a collision, or absent. It then registers per-port transmit enables, one shared transmit symbol, a jam flag, and the expansion activity, symbol and collision outputs. All outputs follow the inputs of the previous cycle, so the latency is one cycle.

Every port has a guard that keeps its own fault state. A port that talks too long is shut down until its stream stops. A port that is involved in too many collisions in a row is partitioned until it completes one reception without any other traffic. A port can also be masked by an isolation input, which comes from carrier-integrity logic outside this block.

Top module: `rep_core`

## Requirements
- R1: When exactly one counted local port is active (active, not isolated, not in jabber shutdown, not partitioned), no expansion activity is present and no jam is in progress, the next cycle has `tx_sym_o` equal to that port's symbol, `tx_en_o` set for every other port that is neither isolated nor jabbered and clear for the source port, `xp_act_o` = 1, `xp_sym_o` equal to the source symbol and `jam_o` = 0.
- R2: When only the expansion port is active, the next cycle has `tx_en_o` set for every port that is neither isolated nor jabbered, `tx_sym_o` = `xp_sym_i` and `xp_act_o` = 0.
- R3: Two or more simultaneous sources (counted local ports plus expansion activity), or `xp_col_i` = 1, cause `jam_o` = 1 in the next cycle. Jam then continues while any counted port, expansion activity or expansion collision remains. During jam, `tx_en_o` covers every port that is neither isolated nor jabbered. `xp_col_o` = 1 exactly when two or more counted local ports were active.
- R4: During jam, `tx_sym_o` is JAM_A (default 5'h15) in the first jam cycle. It then alternates JAM_B (default 5'h0A), JAM_A, and so on for each further jam cycle.
- R5: A port whose activity lasts more than JAB_CYC consecutive cycles enters jabber shutdown. It is still forwarded in cycle JAB_CYC+1 of the stream and is ignored as a source and excluded from `tx_en_o` from cycle JAB_CYC+2. Shutdown ends in the cycle its activity drops.
- R6: A port that ends a reception during which another source or an expansion collision was present increments its collision count. On the (PART_LIMIT+1)th such reception in a row (default 61), the port becomes partitioned. A partitioned port is ignored as a source but still receives `tx_en_o`.
- R7: A non-partitioned port that ends a reception without any other source or expansion collision clears its collision count.
- R8: A partitioned port leaves the partitioned state when it ends a reception during which no other counted source, expansion activity or expansion collision was present. A reception that saw other traffic leaves it partitioned.
- R9: A port with `iso_i` set is never a source and never has `tx_en_o` set in the following cycle.
- R10: During and right after reset, `tx_en_o`, `jam_o`, `xp_act_o` and `xp_col_o` are 0, and `tx_sym_o` and `xp_sym_o` hold the idle symbol (all ones). All guard state clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz symbol clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_act_i | input | 4 | Receive activity per twisted-pair port |
| rx_sym_i | input | 20 | Received 5-bit symbol per port, port p at bits [5p+4:5p] |
| iso_i | input | 4 | Isolation mask per port from carrier-integrity logic |
| xp_act_i | input | 1 | Activity on the expansion port |
| xp_sym_i | input | 5 | Symbol from the expansion port |
| xp_col_i | input | 1 | Collision signalled from the expansion side |
| tx_en_o | output | 4 | Transmit enable per twisted-pair port |
| tx_sym_o | output | 5 | Shared transmit symbol (data, jam pattern or idle) |
| jam_o | output | 1 | Jam in progress |
| xp_act_o | output | 1 | Local receive activity toward the expansion port |
| xp_sym_o | output | 5 | Symbol driven toward the expansion port |
| xp_col_o | output | 1 | Collision between local ports |

## Verification
The assertions assume that `iso_i` and `xp_col_i` have known values at every rising edge after reset, and that an expansion collision input is meant to force jam on its own, regardless of local activity. The stimulus changes inputs only two time units after a rising edge. It brings reset up with all inputs at zero. The random phase toggles activity with low probability per cycle and pulses the expansion collision rarely, so that runs of forwarding, jam, jabber and mask changes all occur. Directed sequences reach the exact jabber boundary, the 60th and 61st consecutive collisions, and both kinds of partition recovery.

// File: rtl/rep_pkg.sv
package rep_pkg;

    // Forwarding decision made each cycle by the arbiter.
    typedef enum logic [1:0] {
        FWD_IDLE  = 2'd0,
        FWD_LOCAL = 2'd1,
        FWD_EXP   = 2'd2,
        FWD_JAM   = 2'd3
    } fwd_mode_e;

endpackage

// File: rtl/rep_port_guard.sv
// Per-port protection: jabber shutdown and consecutive-collision partition.
module rep_port_guard #(
    parameter int JAB_CYC    = 16384,
    parameter int PART_LIMIT = 60,
    localparam int RUN_W     = $clog2(JAB_CYC + 1),
    localparam int CC_W      = $clog2(PART_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_act_i,       // activity, already masked by isolation
    input  logic others_busy_i,  // some other source or expansion collision
    output logic jab_o,
    output logic part_o
);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic [CC_W-1:0]  cc;
        logic             jab;
        logic             part;
        logic             dirty;
        logic             rxq;
    } guard_t;

    guard_t     g_d, g_q;
    logic       eff;
    logic       ended;
    logic [CC_W:0] cc_inc;

    always_comb begin
        g_d    = g_q;
        eff    = rx_act_i && !g_q.jab;
        ended  = g_q.rxq && !rx_act_i;
        cc_inc = {1'b0, g_q.cc} + (CC_W+1)'(1);

        // stream length, saturating at the limit
        if (!rx_act_i) begin
            g_d.run = '0;
        end else if (g_q.run != RUN_W'(JAB_CYC)) begin
            g_d.run = g_q.run + RUN_W'(1);
        end

        g_d.jab   = rx_act_i && (g_q.jab || (g_q.run == RUN_W'(JAB_CYC)));
        g_d.dirty = rx_act_i && (g_q.dirty || (eff && others_busy_i));
        g_d.rxq   = rx_act_i;

        if (ended) begin
            if (g_q.part) begin
                if (!g_q.dirty) begin
                    g_d.part = 1'b0;
                    g_d.cc   = '0;
                end
            end else if (g_q.dirty) begin
                if (cc_inc > (CC_W+1)'(PART_LIMIT)) begin
                    g_d.part = 1'b1;
                    g_d.cc   = '0;
                end else begin
                    g_d.cc = cc_inc[CC_W-1:0];
                end
            end else begin
                g_d.cc = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign jab_o  = g_q.jab;
    assign part_o = g_q.part;

endmodule

// File: rtl/rep_arbiter.sv
// Source counting, collision detection and forwarding decision.
module rep_arbiter import rep_pkg::*; #(
    parameter int NPORTS = 4,
    localparam int SRC_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int CNT_W = $clog2(NPORTS + 2)
) (
    input  logic [NPORTS-1:0] counted_i,
    input  logic              xp_act_i,
    input  logic              xp_col_i,
    input  logic              jam_q_i,
    output fwd_mode_e         mode_o,
    output logic [SRC_W-1:0]  src_o,
    output logic              multi_local_o,
    output logic [NPORTS-1:0] others_busy_o,
    output logic              jam_d_o
);

    logic [CNT_W-1:0] n_local;
    logic [CNT_W-1:0] n_src;
    logic             collide;
    logic             busy;

    always_comb begin
        n_local = '0;
        src_o   = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (counted_i[p]) begin
                n_local = n_local + CNT_W'(1);
                src_o   = SRC_W'(p);
            end
        end
        n_src   = n_local + CNT_W'(xp_act_i);
        collide = (n_src >= CNT_W'(2)) || xp_col_i;
        busy    = (n_local != '0) || xp_act_i || xp_col_i;
        jam_d_o = collide || (jam_q_i && busy);
        multi_local_o = (n_local >= CNT_W'(2));

        for (int p = 0; p < NPORTS; p++) begin
            others_busy_o[p] = ((n_local - CNT_W'(counted_i[p])) != '0)
                               || xp_act_i || xp_col_i;
        end

        if (jam_d_o) begin
            mode_o = FWD_JAM;
        end else if (n_local == CNT_W'(1)) begin
            mode_o = FWD_LOCAL;
        end else if (xp_act_i) begin
            mode_o = FWD_EXP;
        end else begin
            mode_o = FWD_IDLE;
        end
    end

endmodule

// File: rtl/rep_core.sv
module rep_core import rep_pkg::*; #(
    parameter int NPORTS                 = 4,
    parameter int SYM_W                  = 5,
    parameter int JAB_CYC                = 16384,
    parameter int PART_LIMIT             = 60,
    parameter logic [SYM_W-1:0] JAM_A    = 'h15,
    parameter logic [SYM_W-1:0] JAM_B    = 'h0A,
    parameter logic [SYM_W-1:0] IDLE_SYM = '1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORTS-1:0]       rx_act_i,
    input  logic [NPORTS*SYM_W-1:0] rx_sym_i,
    input  logic [NPORTS-1:0]       iso_i,
    input  logic                    xp_act_i,
    input  logic [SYM_W-1:0]        xp_sym_i,
    input  logic                    xp_col_i,
    output logic [NPORTS-1:0]       tx_en_o,
    output logic [SYM_W-1:0]        tx_sym_o,
    output logic                    jam_o,
    output logic                    xp_act_o,
    output logic [SYM_W-1:0]        xp_sym_o,
    output logic                    xp_col_o
);

    localparam int SRC_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    typedef struct packed {
        logic              jam;
        logic              ph;
        logic [NPORTS-1:0] tx_en;
        logic [SYM_W-1:0]  tx_sym;
        logic              xp_act;
        logic [SYM_W-1:0]  xp_sym;
        logic              xp_col;
    } core_t;

    core_t             r_d, r_q;
    logic [NPORTS-1:0] rx_act;
    logic [NPORTS-1:0] jab;
    logic [NPORTS-1:0] part;
    logic [NPORTS-1:0] counted;
    logic [NPORTS-1:0] elig;
    logic [NPORTS-1:0] others_busy;
    fwd_mode_e         mode;
    logic [SRC_W-1:0]  src;
    logic              multi_local;
    logic              jam_d;
    logic [SYM_W-1:0]  src_sym;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign rx_act[p]  = rx_act_i[p] && !iso_i[p];
        assign counted[p] = rx_act[p] && !jab[p] && !part[p];
        assign elig[p]    = !iso_i[p] && !jab[p];

        rep_port_guard #(
            .JAB_CYC    (JAB_CYC),
            .PART_LIMIT (PART_LIMIT)
        ) u_guard (
            .clk           (clk),
            .rst_n         (rst_n),
            .rx_act_i      (rx_act[p]),
            .others_busy_i (others_busy[p]),
            .jab_o         (jab[p]),
            .part_o        (part[p])
        );
    end

    rep_arbiter #(
        .NPORTS (NPORTS)
    ) u_arb (
        .counted_i     (counted),
        .xp_act_i      (xp_act_i),
        .xp_col_i      (xp_col_i),
        .jam_q_i       (r_q.jam),
        .mode_o        (mode),
        .src_o         (src),
        .multi_local_o (multi_local),
        .others_busy_o (others_busy),
        .jam_d_o       (jam_d)
    );

    assign src_sym = rx_sym_i[src*SYM_W +: SYM_W];

    always_comb begin
        r_d        = r_q;
        r_d.jam    = jam_d;
        r_d.ph     = jam_d && r_q.jam && !r_q.ph;
        r_d.tx_en  = '0;
        r_d.tx_sym = IDLE_SYM;
        r_d.xp_act = (counted != '0);
        r_d.xp_sym = IDLE_SYM;
        r_d.xp_col = multi_local;

        unique case (mode)
            FWD_JAM: begin
                r_d.tx_en  = elig;
                r_d.tx_sym = r_d.ph ? JAM_B : JAM_A;
            end
            FWD_LOCAL: begin
                r_d.tx_en  = elig & ~counted;
                r_d.tx_sym = src_sym;
                r_d.xp_sym = src_sym;
            end
            FWD_EXP: begin
                r_d.tx_en  = elig;
                r_d.tx_sym = xp_sym_i;
            end
            FWD_IDLE: begin
                r_d.tx_en  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.tx_sym <= IDLE_SYM;
            r_q.xp_sym <= IDLE_SYM;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_en_o  = r_q.tx_en;
    assign tx_sym_o = r_q.tx_sym;
    assign jam_o    = r_q.jam;
    assign xp_act_o = r_q.xp_act;
    assign xp_sym_o = r_q.xp_sym;
    assign xp_col_o = r_q.xp_col;

endmodule

// File: rtl/rep_core_chk.sv
module rep_core_chk #(
    parameter int NPORTS              = 4,
    parameter int SYM_W               = 5,
    parameter logic [SYM_W-1:0] JAM_A = 'h15,
    parameter logic [SYM_W-1:0] JAM_B = 'h0A
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPORTS-1:0] iso_i,
    input logic              xp_col_i,
    input logic [NPORTS-1:0] tx_en_o,
    input logic [SYM_W-1:0]  tx_sym_o,
    input logic              jam_o,
    input logic              xp_act_o,
    input logic              xp_col_o
);

    // R3
    local_col_jams_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xp_col_o |-> jam_o);

    // R3
    ext_col_jams_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xp_col_i |=> jam_o);

    // R4
    jam_symbol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jam_o |-> (tx_sym_o == JAM_A || tx_sym_o == JAM_B));

    // R4
    jam_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jam_o && $past(jam_o)) |-> (tx_sym_o != $past(tx_sym_o)));

    // R9
    iso_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_o & $past(iso_i)) == '0);

    // R1
    no_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xp_act_o && !jam_o) |-> ($countones(tx_en_o) < NPORTS));

endmodule

bind rep_core rep_core_chk #(
    .NPORTS (NPORTS),
    .SYM_W  (SYM_W),
    .JAM_A  (JAM_A),
    .JAM_B  (JAM_B)
) u_chk (.*);

// File: tb/rep_core_test.sv
module rep_core_test;

    localparam int NP  = 4;
    localparam int SW  = 5;
    localparam int JAB = 40;
    localparam int LIM = 60;
    localparam logic [SW-1:0] JA   = 5'h15;
    localparam logic [SW-1:0] JB   = 5'h0A;
    localparam logic [SW-1:0] IDLE = 5'h1F;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [NP-1:0]     act   = '0;
    logic [NP*SW-1:0]  sym   = '0;
    logic [NP-1:0]     iso   = '0;
    logic              xa    = 1'b0;
    logic [SW-1:0]     xs    = '0;
    logic              xc    = 1'b0;
    logic [NP-1:0]     tx_en;
    logic [SW-1:0]     tx_sym;
    logic              jam;
    logic              xact;
    logic [SW-1:0]     xsym;
    logic              xcol;

    rep_core #(
        .NPORTS     (NP),
        .SYM_W      (SW),
        .JAB_CYC    (JAB),
        .PART_LIMIT (LIM)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_act_i (act),
        .rx_sym_i (sym),
        .iso_i    (iso),
        .xp_act_i (xa),
        .xp_sym_i (xs),
        .xp_col_i (xc),
        .tx_en_o  (tx_en),
        .tx_sym_o (tx_sym),
        .jam_o    (jam),
        .xp_act_o (xact),
        .xp_sym_o (xsym),
        .xp_col_o (xcol)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model state
    int m_run [NP];
    int m_cc  [NP];
    bit m_jab [NP];
    bit m_part[NP];
    bit m_dirty[NP];
    bit m_rxq [NP];
    bit m_jam, m_ph;
    logic [NP-1:0] e_en;
    logic [SW-1:0] e_sym, e_xsym;
    bit e_jam, e_xact, e_xcol;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_run[p] = 0; m_cc[p] = 0; m_jab[p] = 0;
            m_part[p] = 0; m_dirty[p] = 0; m_rxq[p] = 0;
        end
        m_jam = 0; m_ph = 0;
    endtask

    task automatic model_step();
        bit rxa[NP];
        bit cnt[NP];
        int ln;
        bit col, busy, jn, ph, ended, eff, oth;
        logic [NP-1:0] elig;
        ln = 0;
        for (int p = 0; p < NP; p++) begin
            rxa[p]  = act[p] && !iso[p];
            cnt[p]  = rxa[p] && !m_jab[p] && !m_part[p];
            elig[p] = !iso[p] && !m_jab[p];
            if (cnt[p]) ln++;
        end
        col  = ((ln + int'(xa)) >= 2) || xc;
        busy = (ln != 0) || xa || xc;
        jn   = col || (m_jam && busy);
        ph   = jn && m_jam && !m_ph;
        e_jam  = jn;
        e_xact = (ln != 0);
        e_xcol = (ln >= 2);
        e_xsym = IDLE;
        e_en   = '0;
        e_sym  = IDLE;
        if (jn) begin
            e_en  = elig;
            e_sym = ph ? JB : JA;
        end else if (ln == 1) begin
            for (int p = 0; p < NP; p++) begin
                if (cnt[p]) begin
                    e_sym  = sym[p*SW +: SW];
                    e_xsym = sym[p*SW +: SW];
                end
                e_en[p] = elig[p] && !cnt[p];
            end
        end else if (xa) begin
            e_en  = elig;
            e_sym = xs;
        end
        for (int p = 0; p < NP; p++) begin
            eff   = rxa[p] && !m_jab[p];
            oth   = ((ln - int'(cnt[p])) != 0) || xa || xc;
            ended = m_rxq[p] && !rxa[p];
            if (ended) begin
                if (m_part[p]) begin
                    if (!m_dirty[p]) begin m_part[p] = 0; m_cc[p] = 0; end
                end else if (m_dirty[p]) begin
                    if (m_cc[p] + 1 > LIM) begin m_part[p] = 1; m_cc[p] = 0; end
                    else m_cc[p] = m_cc[p] + 1;
                end else begin
                    m_cc[p] = 0;
                end
            end
            m_dirty[p] = rxa[p] && (m_dirty[p] || (eff && oth));
            m_jab[p]   = rxa[p] && (m_jab[p] || m_run[p] == JAB);
            m_run[p]   = !rxa[p] ? 0 : ((m_run[p] == JAB) ? JAB : m_run[p] + 1);
            m_rxq[p]   = rxa[p];
        end
        m_jam = jn;
        m_ph  = ph;
    endtask

    // Drive current inputs through one clock edge and compare with the model.
    task automatic step(string tag);
        model_step();
        @(posedge clk);
        #2;
        chk(tag, {17'd0, tx_en, tx_sym, jam, xact, xsym, xcol},
                 {17'd0, e_en, e_sym, e_jam, e_xact, e_xsym, e_xcol});
    endtask

    task automatic set_port(int p, bit a, logic [SW-1:0] s);
        act[p] = a;
        sym[p*SW +: SW] = s;
    endtask

    task automatic collide_once();
        set_port(1, 1, 5'h0C); xa = 1; xs = 5'h03;
        step("R6 collision");
        step("R6 collision");
        act = '0; xa = 0;
        step("R6 collision");
        step("R6 collision");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        chk("R10 tx_en/jam/xact/xcol", {28'd0, tx_en}, 32'd0);
        chk("R10 flags", {29'd0, jam, xact, xcol}, 32'd0);
        chk("R10 tx_sym idle", {27'd0, tx_sym}, {27'd0, IDLE});
        chk("R10 xp_sym idle", {27'd0, xsym}, {27'd0, IDLE});
        @(negedge clk);
        rst_n = 1'b1;
        step("R10 idle after reset");
        chk("R10 idle tx_en", {28'd0, tx_en}, 32'd0);

        // R1: single local source on port 1
        set_port(1, 1, 5'h0E);
        step("R1");
        chk("R1 tx_en", {28'd0, tx_en}, 32'b1101);
        chk("R1 tx_sym", {27'd0, tx_sym}, 32'h0E);
        chk("R1 xp_act/xp_sym", {26'd0, xact, xsym}, {26'd0, 1'b1, 5'h0E});
        set_port(1, 1, 5'h11);
        step("R1");
        act = '0;
        step("R1"); step("R1");

        // R2: expansion source
        xa = 1; xs = 5'h07;
        step("R2");
        chk("R2 tx_en", {28'd0, tx_en}, 32'b1111);
        chk("R2 sym/xact", {26'd0, xact, tx_sym}, {26'd0, 1'b0, 5'h07});
        xa = 0;
        step("R2"); step("R2");

        // R3/R4: two local ports start together
        set_port(0, 1, 5'h01); set_port(2, 1, 5'h02);
        step("R3");
        chk("R3 jam/xcol", {30'd0, jam, xcol}, 32'b11);
        chk("R4 first jam symbol", {27'd0, tx_sym}, {27'd0, JA});
        step("R4");
        chk("R4 second jam symbol", {27'd0, tx_sym}, {27'd0, JB});
        set_port(2, 0, 5'h00);
        step("R3");
        chk("R3 jam persists", {27'd0, jam, tx_en}, {27'd0, 1'b1, 4'b1111});
        chk("R4 third jam symbol", {27'd0, tx_sym}, {27'd0, JA});
        act = '0;
        step("R3");
        chk("R3 jam ends", {31'd0, jam}, 32'd0);

        // R3: expansion collision alone
        xc = 1;
        step("R3");
        chk("R3 ext collision", {30'd0, jam, xcol}, 32'b10);
        xc = 0;
        step("R3");
        chk("R3 ext collision ends", {31'd0, jam}, 32'd0);

        // R9: isolation mask
        iso = 4'b1000;
        set_port(0, 1, 5'h09); set_port(3, 1, 5'h0B);
        step("R9");
        chk("R9 tx_en", {27'd0, jam, tx_en}, {27'd0, 1'b0, 4'b0110});
        act = '0;
        step("R9");
        iso = '0;
        step("R9");

        // R5: jabber on port 2
        for (int k = 0; k < JAB + 1; k++) begin
            set_port(2, 1, 5'($urandom));
            step("R5");
        end
        chk("R5 still forwarded at limit", {28'd0, tx_en}, 32'b1011);
        step("R5");
        chk("R5 shut down", {27'd0, xact, tx_en}, 32'd0);
        set_port(0, 1, 5'h06);
        step("R5");
        chk("R5 no tx to jabbered port", {27'd0, jam, tx_en}, {27'd0, 1'b0, 4'b1010});
        act = '0;
        step("R5");
        set_port(2, 1, 5'h0D);
        step("R5");
        chk("R5 recovered", {28'd0, tx_en}, 32'b1011);
        act = '0;
        step("R5"); step("R5");

        // R6/R7: consecutive collisions on port 1 against the expansion port
        for (int k = 0; k < LIM; k++) collide_once();
        set_port(1, 1, 5'h05);
        step("R6");
        chk("R6 not partitioned after limit", {27'd0, xact, tx_en}, {27'd0, 1'b1, 4'b1101});
        act = '0;
        step("R6");
        collide_once();
        set_port(1, 1, 5'h05);
        step("R7");
        chk("R7 count cleared by clean reception", {27'd0, xact, tx_en}, {27'd0, 1'b1, 4'b1101});
        act = '0;
        step("R7");
        for (int k = 0; k < LIM + 1; k++) collide_once();
        set_port(1, 1, 5'h05);
        step("R6");
        chk("R6 partitioned ignored", {27'd0, xact, tx_en}, 32'd0);
        set_port(0, 1, 5'h08);
        step("R6");
        chk("R6 partitioned still receives", {27'd0, jam, tx_en}, {27'd0, 1'b0, 4'b1110});
        act = '0;
        step("R8");
        set_port(1, 1, 5'h05);
        step("R8");
        chk("R8 busy reception keeps partition", {31'd0, xact}, 32'd0);
        act = '0;
        step("R8");
        set_port(1, 1, 5'h05);
        step("R8");
        chk("R8 recovered", {27'd0, xact, tx_en}, {27'd0, 1'b1, 4'b1101});
        act = '0;
        step("R8"); step("R8");

        // R1/R3: constrained random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            for (int p = 0; p < NP; p++) begin
                if ($urandom % 8 == 0)  act[p] = ~act[p];
                if ($urandom % 97 == 0) iso[p] = ~iso[p];
                sym[p*SW +: SW] = 5'($urandom);
            end
            if ($urandom % 12 == 0) xa = ~xa;
            xs = 5'($urandom);
            xc = ($urandom % 50 == 0);
            step("R1 R3 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule